// File: doc/BRIEF.md
# Musical Note Square-Wave Generator

This block turns a slow time-base strobe into an audible square wave whose pitch is chosen by a small note code. A processor output port writes a 4-bit code into the block. Code zero silences the output. Codes one to fifteen select fifteen ascending semitone-spaced notes that span a little over an octave, starting from a base pitch given as a parameter.

Each code reads a half-period length from a divisor table. The table is computed when the design is elaborated. A down-counter advances only on a one-cycle tick enable, which arrives at the time-base rate (30 kHz by default) in the system clock domain. When the counter expires, it reloads from the table and the output level flips.

Writing a new code restarts the waveform at once from a low level, so a new pitch never waits for the old period to finish.

Top module: `tone_gen_top`

## Requirements
- R1: After a synchronous reset the output is low and the note code is zero, so with no further write the output stays low whatever ticks arrive.
- R2: While the note code is zero the output is held low and ticks have no effect on it.
- R3: Code k (1..15) gives a half period of N_k ticks, N_k = round(TICK_HZ / (2·f_k)), with f_k = BASE_CHZ/100 · 2^((k-1)/12). With the defaults (30000, 44000) this gives N_1 = 34 and N_15 = 15, and N is non-increasing in k.
- R4: In a cycle with no tick and no write, neither the output nor the internal count changes.
- R5: The output toggles only on a tick that finds the count at zero; the count then reloads to N_k-1. In steady state every high and every low phase lasts exactly N_k ticks.
- R6: A write of a non-zero code drives the output low within two clock cycles. The first toggle then falls on the N_k-th tick counted from the second clock edge after the write.
- R7: A write of code zero while a tone is sounding drives the output low within two clock cycles, and it stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle time-base strobe (30 kHz rate) |
| note_we | input | 1 | Note code write strobe from the processor port |
| note_wdata | input | CODE_W | Note code; 0 = silence |
| tone_out | output | 1 | Registered square-wave output |

## Verification
The main function is tried with the two table extremes (codes 1 and 15) and with codes drawn at random. For each code the bench counts the ticks to the first edge and across two further half periods. The first count separates a correct restart from a stale counter. The later counts separate the reload value N-1 from off-by-one reloads. Runs of idle cycles without ticks show that the counter advances only on the enable. Writes made while the output is high, of a new note and of code zero, separate an immediate restart or silence from one that waits for the current phase to end.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Half-period length in ticks for note code 'code' (1-based semitone steps).
  function automatic int half_period_ticks(input int code, input int base_chz,
                                           input int tick_hz);
    real f;
    f = real'(base_chz) / 100.0;
    for (int i = 1; i < code; i++) begin
      f = f * 1.0594630943592953;
    end
    return $rtoi(real'(tick_hz) / (2.0 * f) + 0.5);
  endfunction

endpackage

// File: rtl/tone_note_reg.sv
module tone_note_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] note_q,
  output logic [CODE_W-1:0] next_note,
  output logic              restart_q
);

  always_comb begin
    if (rst)     next_note = '0;
    else if (we) next_note = wdata;
    else         next_note = note_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      note_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      note_q    <= next_note;
      restart_q <= we;
    end
  end

  // R1
  reset_clears_note_chk: assert property (@(posedge clk)
    rst |=> (note_q == '0) && !restart_q);

  // R6
  write_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> restart_q && (note_q == $past(wdata)));

endmodule

// File: rtl/tone_div_rom.sv
module tone_div_rom
  import tone_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int CNT_W    = 8,
  parameter int BASE_CHZ = 44000,
  parameter int TICK_HZ  = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] addr,
  output logic [CNT_W-1:0]  q
);

  localparam int DEPTH = 1 << CODE_W;

  logic [CNT_W-1:0] table_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    if (g == 0) begin : g_silent
      assign table_mem[g] = '0;
    end else begin : g_note
      assign table_mem[g] = CNT_W'(half_period_ticks(g, BASE_CHZ, TICK_HZ));
    end
  end

  // Registered read port, block-RAM style (no reset on the data path).
  always_ff @(posedge clk) begin
    q <= table_mem[addr];
  end

  // R3
  silent_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> (q == '0));

  // R3
  nonzero_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (addr != '0) |=> (q != '0));

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             tone_q
);

  logic [CNT_W-1:0] cnt_q;
  logic             silent;

  assign silent = (reload == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (restart || silent) begin
      tone_q <= 1'b0;
      cnt_q  <= silent ? '0 : reload - 1'b1;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q  <= reload - 1'b1;
        tone_q <= ~tone_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R2
  silent_low_chk: assert property (@(posedge clk) disable iff (rst)
    silent |=> !tone_q);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart && !silent) |=> $stable(tone_q) && $stable(cnt_q));

  // R5
  mid_count_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && !silent && cnt_q != '0) |=> $stable(tone_q));

  // R5
  expiry_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && !silent && cnt_q == '0)
      |=> (tone_q != $past(tone_q)) && (cnt_q == $past(reload) - 1'b1));

  // R6
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && !silent) |=> !tone_q && (cnt_q == $past(reload) - 1'b1));

endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top #(
  parameter int CODE_W   = 4,
  parameter int CNT_W    = 8,
  parameter int BASE_CHZ = 44000,
  parameter int TICK_HZ  = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              note_we,
  input  logic [CODE_W-1:0] note_wdata,
  output logic              tone_out
);

  logic [CODE_W-1:0] note_q;
  logic [CODE_W-1:0] next_note;
  logic              restart_q;
  logic [CNT_W-1:0]  reload;

  tone_note_reg #(.CODE_W(CODE_W)) u_note (
    .clk       (clk),
    .rst       (rst),
    .we        (note_we),
    .wdata     (note_wdata),
    .note_q    (note_q),
    .next_note (next_note),
    .restart_q (restart_q)
  );

  tone_div_rom #(
    .CODE_W   (CODE_W),
    .CNT_W    (CNT_W),
    .BASE_CHZ (BASE_CHZ),
    .TICK_HZ  (TICK_HZ)
  ) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (next_note),
    .q    (reload)
  );

  tone_divider #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_en),
    .restart (restart_q),
    .reload  (reload),
    .tone_q  (tone_out)
  );

  // R7
  zero_write_silences_chk: assert property (@(posedge clk) disable iff (rst)
    (restart_q && note_q == '0) |=> !tone_out);

endmodule

// File: tb/sim_tone_gen_top.sv
module sim_tone_gen_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       note_we = 1'b0;
  logic [3:0] note_wdata = '0;
  logic       tone_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tone_gen_top u0 (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .note_we    (note_we),
    .note_wdata (note_wdata),
    .tone_out   (tone_out)
  );

  function automatic int exp_ticks(input int code);
    real f;
    f = 440.0 * (2.0 ** ((code - 1) / 12.0));
    return $rtoi(15000.0 / f + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
  endtask

  task automatic write_note(input int code);
    @(negedge clk) begin note_we = 1'b1; note_wdata = 4'(code); end
    @(negedge clk) note_we = 1'b0;
    @(negedge clk);
  endtask

  // Ticks until the output changes (0 if it never does within lim).
  task automatic ticks_to_edge(input int lim, output int n);
    logic prev;
    prev = tone_out;
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      pulse_tick();
      if (tone_out != prev) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic run_note(input int code);
    int n;
    write_note(code);
    check("R6 low after write", int'(tone_out), 0);
    ticks_to_edge(80, n);
    check($sformatf("R3/R6 first edge code %0d", code), n, exp_ticks(code));
    check("R5 high after first edge", int'(tone_out), 1);
    for (int h = 0; h < 2; h++) begin
      ticks_to_edge(80, n);
      check($sformatf("R5 half period code %0d", code), n, exp_ticks(code));
    end
  endtask

  initial begin
    int n;
    int code;
    logic held;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset output", int'(tone_out), 0);
    ticks_to_edge(50, n);
    check("R1/R2 silent after reset", n, 0);

    check("R3 table end low", exp_ticks(1), 34);
    check("R3 table end high", exp_ticks(15), 15);
    run_note(1);
    run_note(15);
    for (int r = 0; r < 10; r++) begin
      code = 1 + int'($urandom_range(14));
      run_note(code);
    end

    // R4: no ticks, output and count hold
    write_note(5);
    ticks_to_edge(80, n);
    held = tone_out;
    repeat (25) @(negedge clk);
    check("R4 idle output", int'(tone_out), int'(held));
    ticks_to_edge(80, n);
    check("R4 count held while idle", n, exp_ticks(5));

    // R6: new note written while output is high
    write_note(3);
    ticks_to_edge(80, n);
    check("R6 high before rewrite", int'(tone_out), 1);
    pulse_tick();
    write_note(12);
    check("R6 rewrite low", int'(tone_out), 0);
    ticks_to_edge(80, n);
    check("R6 rewrite first edge", n, exp_ticks(12));

    // R7: code zero written while high
    check("R7 high before silence", int'(tone_out), 1);
    write_note(0);
    check("R7 silenced", int'(tone_out), 0);
    ticks_to_edge(60, n);
    check("R2/R7 stays silent", n, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule